// File: doc/BRIEF.md
# Subtract Pipeline Hazard and Forwarding Controller

This controller manages hazards for a five-stage pipeline (fetch, decode, two execute stages EX1 and EX2, write-back). The pipeline runs two subtract flavours: a short one whose result can be ready after a single execute stage, and a long one that needs both execute stages. It also has a no-operation code. The controller receives the decoded fields of the instruction sitting in decode. It keeps its own shadow of the slots in EX1, EX2 and write-back, and carries the decisions for each instruction along with it as it moves down the pipe. The arithmetic, the operand values and the register file are outside this block.

The controller assumes a fixed operand-timing model. Source operands are read from the register file as an instruction enters EX1. The register file makes a write-back write visible to a read in the same cycle. A producer two or more slots ahead is therefore always seen through the register file, so only a dependence on the instruction directly ahead needs handling. There are two bypass paths: the EX2 stage result into EX1, and the write-back value into EX2.

A short subtract is never held back. If the instruction directly ahead of it produces its value late, the short subtract is instead marked to compute in EX2, and it then passes its result through unchanged. A long subtract can only wait. It is held for one cycle when it reads the destination of the instruction directly ahead, and a bubble goes into EX1 during that cycle. The stall indication is combinational from the decode fields. Every other output is registered and describes the instruction that currently occupies EX1 or EX2.

Top module: `sub_hazard_fwd_unit`

## Requirements
- R1: Opcode field: 2'b00 no-op, 2'b01 short subtract, 2'b10 long subtract, 2'b11 reserved and handled as a no-op. Both subtracts write `rd` and read `rs` and `rt`. While `rst` is high, and in the first cycle after it, every registered output is 0, and `stall` is 0 because the EX1 shadow is empty.
- R2: A long subtract in decode raises `stall` in the same cycle if its `rs` or its `rt` equals the `rd` of the real instruction in EX1 and that `rd` is nonzero. In every other case `stall` stays low.
- R3: A short subtract in decode never raises `stall`, whatever its dependences.
- R4: A stall keeps the decode instruction waiting and puts a bubble into EX1. In the next cycle all EX1 outputs are 0. The same instruction is never stalled for two cycles in a row.
- R5: A short subtract that reads the result of a directly preceding short subtract computing in EX1 stays in EX1. While it occupies EX1, `ex1_fwd_rs` and/or `ex1_fwd_rt` are 1 for each matching source.
- R6: A short subtract that reads the result of a directly preceding long subtract, or of a short subtract marked for EX2, is marked for EX2. `ex1_post` is 1 while it is in EX1, and then `ex2_post` is 1 while it is in EX2. `ex2_fwd_rs` and/or `ex2_fwd_rt` are 1 for each matching source while it is in EX2, and its EX1 selects are 0.
- R7: A short subtract with no dependence on the instruction directly ahead computes in EX1, and all of its bypass selects are 0.
- R8: A producer two or more instructions ahead causes no stall, no EX2 placement and no bypass select.
- R9: Destination register 0, no-ops, the reserved code, slots with `id_valid` low, and bubbles never match any source.
- R10: The select for each source is decided on its own. Only the source that matches gets its select, and both are set when both match.
- R11: A long subtract never gets an EX2 placement flag or a bypass select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_op | input | 2 | Opcode of the decode instruction |
| id_rd | input | REG_AW | Destination register of the decode instruction |
| id_rs | input | REG_AW | First source register |
| id_rt | input | REG_AW | Second source register |
| stall | output | 1 | Hold fetch and decode, bubble into EX1 (combinational) |
| ex1_post | output | 1 | Instruction in EX1 defers its computation to EX2 |
| ex1_fwd_rs | output | 1 | EX1 first operand taken from the EX2 result |
| ex1_fwd_rt | output | 1 | EX1 second operand taken from the EX2 result |
| ex2_post | output | 1 | Instruction in EX2 computes there |
| ex2_fwd_rs | output | 1 | EX2 first operand taken from the write-back value |
| ex2_fwd_rt | output | 1 | EX2 second operand taken from the write-back value |

## Verification
The bench aims at the boundary between the two bypass paths. It runs short subtracts after long subtracts and after other deferred short subtracts, including chains of them. If a design got the "late producer" test wrong, it would bypass from EX2 a value that does not exist yet, or it would defer an instruction that had no reason to wait. Dependences through register 0, no-ops, the reserved code and idle decode slots are also covered, because a design that matched those would stall or bypass on nothing. A producer two slots back is tested as well, and a design that reacted to it would lose cycles. Stalled long subtracts are followed through the cycle after the stall to confirm that the bubble reaches EX1 and that the same instruction is not held twice. A long random stream over a few registers then checks all seven outputs against a behavioural model every cycle.

// File: rtl/hfu_pkg.sv
package hfu_pkg;

  // Opcode space of the decode stage; 2'b11 is reserved and treated as a no-op.
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_SUB3 = 2'b01,
    OP_SUB6 = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  // Number of register sources per instruction (rs, rt).
  localparam int NSRC = 2;

endpackage

// File: rtl/hfu_src_match.sv
module hfu_src_match #(
  parameter int AW = 5
) (
  input  logic          prod_live,
  input  logic [AW-1:0] prod_rd,
  input  logic [AW-1:0] src,
  output logic          hit
);

  // Register 0 is hard-wired and never produced, so it never matches.
  assign hit = prod_live && (prod_rd != '0) && (src == prod_rd);

endmodule

// File: rtl/hfu_issue.sv
module hfu_issue
  import hfu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic               id_live,
  input  logic               id_long,
  input  logic [NSRC*AW-1:0] id_src,
  input  logic               prev_live,
  input  logic [1:0]         prev_op,
  input  logic               prev_post,
  input  logic [AW-1:0]      prev_rd,
  output logic               stall,
  output logic               post,
  output logic [NSRC-1:0]    fwd_ex1,
  output logic [NSRC-1:0]    fwd_ex2
);

  logic [NSRC-1:0] hit;
  logic            any_hit;
  logic            prev_slow;
  logic            id_short;

  // One comparator per source operand.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hfu_src_match #(.AW(AW)) u_match (
      .prod_live (prev_live),
      .prod_rd   (prev_rd),
      .src       (id_src[s*AW +: AW]),
      .hit       (hit[s])
    );
  end

  assign any_hit   = |hit;
  assign id_short  = id_live && !id_long;
  // Producer whose value only exists at the end of EX2.
  assign prev_slow = prev_live && ((prev_op == OP_SUB6) || prev_post);

  always_comb begin
    stall   = id_live && id_long && any_hit;
    post    = id_short && any_hit && prev_slow;
    fwd_ex1 = '0;
    fwd_ex2 = '0;
    if (id_short) begin
      if (prev_slow) fwd_ex2 = hit;
      else           fwd_ex1 = hit;
    end
  end

endmodule

// File: rtl/hfu_pipe_slot.sv
module hfu_pipe_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || bubble) q <= '0;
    else               q <= d;
  end

endmodule

// File: rtl/sub_hazard_fwd_unit.sv
module sub_hazard_fwd_unit
  import hfu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [1:0]        id_op,
  input  logic [REG_AW-1:0] id_rd,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  output logic              stall,
  output logic              ex1_post,
  output logic              ex1_fwd_rs,
  output logic              ex1_fwd_rt,
  output logic              ex2_post,
  output logic              ex2_fwd_rs,
  output logic              ex2_fwd_rt
);

  typedef struct packed {
    logic              vld;
    logic [1:0]        op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic              post;
    logic [NSRC-1:0]   f1;
    logic [NSRC-1:0]   f2;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  slot_t id_slot, ex1_q, ex2_q, wb_q;
  logic            id_real, id_long;
  logic            stall_c, post_c;
  logic [NSRC-1:0] f1_c, f2_c;

  assign id_real = id_valid && ((id_op == OP_SUB3) || (id_op == OP_SUB6));
  assign id_long = (id_op == OP_SUB6);

  hfu_issue #(.AW(REG_AW)) u_issue (
    .id_live   (id_real),
    .id_long   (id_long),
    .id_src    ({id_rt, id_rs}),
    .prev_live (ex1_q.vld),
    .prev_op   (ex1_q.op),
    .prev_post (ex1_q.post),
    .prev_rd   (ex1_q.rd),
    .stall     (stall_c),
    .post      (post_c),
    .fwd_ex1   (f1_c),
    .fwd_ex2   (f2_c)
  );

  // No-ops and idle slots enter the pipe as empty slots.
  always_comb begin
    id_slot = '0;
    if (id_real) begin
      id_slot.vld  = 1'b1;
      id_slot.op   = id_op;
      id_slot.rd   = id_rd;
      id_slot.rs   = id_rs;
      id_slot.rt   = id_rt;
      id_slot.post = post_c;
      id_slot.f1   = f1_c;
      id_slot.f2   = f2_c;
    end
  end

  hfu_pipe_slot #(.W(SLOT_W)) u_ex1 (
    .clk (clk), .rst (rst), .bubble (stall_c), .d (id_slot), .q (ex1_q)
  );
  hfu_pipe_slot #(.W(SLOT_W)) u_ex2 (
    .clk (clk), .rst (rst), .bubble (1'b0), .d (ex1_q), .q (ex2_q)
  );
  hfu_pipe_slot #(.W(SLOT_W)) u_wb (
    .clk (clk), .rst (rst), .bubble (1'b0), .d (ex2_q), .q (wb_q)
  );

  assign stall      = stall_c;
  assign ex1_post   = ex1_q.post;
  assign ex1_fwd_rs = ex1_q.f1[0];
  assign ex1_fwd_rt = ex1_q.f1[1];
  assign ex2_post   = ex2_q.post;
  assign ex2_fwd_rs = ex2_q.f2[0];
  assign ex2_fwd_rt = ex2_q.f2[1];

  // Only a long subtract in decode may hold the front end.
  assert_stall_only_long_R3: assert property (@(posedge clk) disable iff (rst)
    stall |-> (id_valid && id_op == OP_SUB6));

  // A stall never blames destination register 0.
  assert_no_zero_stall_R9: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex1_q.vld && ex1_q.rd != '0));

  // The cycle after a stall sees an empty EX1 slot.
  assert_bubble_after_stall_R4: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ex1_q.vld && !ex1_post && !ex1_fwd_rs && !ex1_fwd_rt));

  // EX2-to-EX1 bypass only from a short subtract that already computed in EX1.
  assert_ex1_fwd_source_R5: assert property (@(posedge clk) disable iff (rst)
    (ex1_fwd_rs || ex1_fwd_rt) |->
      (ex2_q.vld && ex2_q.op == OP_SUB3 && !ex2_q.post && ex2_q.rd != '0 &&
       (!ex1_fwd_rs || ex2_q.rd == ex1_q.rs) && (!ex1_fwd_rt || ex2_q.rd == ex1_q.rt)));

  // WB-to-EX2 bypass only into a deferred short subtract, from a late producer.
  assert_ex2_fwd_source_R6: assert property (@(posedge clk) disable iff (rst)
    (ex2_fwd_rs || ex2_fwd_rt) |->
      (ex2_post && wb_q.vld && (wb_q.op == OP_SUB6 || wb_q.post) && wb_q.rd != '0 &&
       (!ex2_fwd_rs || wb_q.rd == ex2_q.rs) && (!ex2_fwd_rt || wb_q.rd == ex2_q.rt)));

  // A deferred instruction is a short subtract and uses no EX1 bypass.
  assert_post_short_R6: assert property (@(posedge clk) disable iff (rst)
    ex1_post |-> (ex1_q.op == OP_SUB3 && !ex1_fwd_rs && !ex1_fwd_rt));

  // The EX2 placement flag follows the instruction from EX1 into EX2.
  assert_post_travels_R6: assert property (@(posedge clk) disable iff (rst)
    ex1_post |=> ex2_post);

  // Long subtracts carry no placement flag and no bypass select.
  assert_long_plain_R11: assert property (@(posedge clk) disable iff (rst)
    (ex1_q.vld && ex1_q.op == OP_SUB6) |->
      (!ex1_post && !ex1_fwd_rs && !ex1_fwd_rt && ex1_q.f2 == '0));

endmodule

// File: tb/sub_hazard_fwd_unit_test.sv
module sub_hazard_fwd_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 5;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    bit          valid;
    bit [1:0]    op;
    bit [AW-1:0] rd, rs, rt;
  } instr_t;

  typedef struct {
    bit          live, longop, late;
    bit [AW-1:0] rd;
    bit [1:0]    f1, f2;
  } model_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          id_valid = 1'b0;
  logic [1:0]    id_op = 2'b00;
  logic [AW-1:0] id_rd = '0, id_rs = '0, id_rt = '0;
  logic          stall, ex1_post, ex1_fwd_rs, ex1_fwd_rt;
  logic          ex2_post, ex2_fwd_rs, ex2_fwd_rt;

  int     checks = 0;
  int     errors = 0;
  bit     done   = 1'b0;
  int     stall_run = 0;
  string  seg;
  instr_t prog[$];
  model_t m1, m2;

  always #(CLK_PERIOD/2) clk = ~clk;

  sub_hazard_fwd_unit #(.REG_AW(AW)) uut (
    .clk (clk), .rst (rst), .id_valid (id_valid), .id_op (id_op),
    .id_rd (id_rd), .id_rs (id_rs), .id_rt (id_rt),
    .stall (stall), .ex1_post (ex1_post), .ex1_fwd_rs (ex1_fwd_rs),
    .ex1_fwd_rt (ex1_fwd_rt), .ex2_post (ex2_post),
    .ex2_fwd_rs (ex2_fwd_rs), .ex2_fwd_rt (ex2_fwd_rt)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%b expected=%b at %0t", req, seg, what, act, exp, $time);
    end
  endtask

  task automatic put(bit v, bit [1:0] op, int rd, int rs, int rt);
    instr_t i;
    i.valid = v; i.op = op; i.rd = rd[AW-1:0]; i.rs = rs[AW-1:0]; i.rt = rt[AW-1:0];
    prog.push_back(i);
  endtask

  // One cycle: drive decode, compare all outputs with the model, advance the model.
  task automatic step();
    instr_t c;
    model_t n;
    bit     real_i, hs, ht, slow, exp_stall;
    @(negedge clk);
    if (prog.size() > 0) c = prog[0];
    else begin c.valid = 0; c.op = 0; c.rd = 0; c.rs = 0; c.rt = 0; end
    id_valid = c.valid; id_op = c.op; id_rd = c.rd; id_rs = c.rs; id_rt = c.rt;
    #1;
    real_i = c.valid && (c.op == 2'b01 || c.op == 2'b10);
    hs = 0; ht = 0;
    if (real_i && m1.live && m1.rd != 0) begin
      if (c.rs == m1.rd) hs = 1;
      if (c.rt == m1.rd) ht = 1;
    end
    slow = m1.longop || m1.late;
    exp_stall = real_i && c.op == 2'b10 && (hs || ht);

    chk((c.op == 2'b01) ? "R3" : "R2", "stall", stall, exp_stall);
    chk("R6", "ex1_post", ex1_post, m1.late);
    chk("R5", "ex1_fwd_rs", ex1_fwd_rs, m1.f1[0]);
    chk("R5", "ex1_fwd_rt", ex1_fwd_rt, m1.f1[1]);
    chk("R6", "ex2_post", ex2_post, m2.late);
    chk("R6", "ex2_fwd_rs", ex2_fwd_rs, m2.f2[0]);
    chk("R6", "ex2_fwd_rt", ex2_fwd_rt, m2.f2[1]);

    if (stall === 1'b1) begin
      stall_run++;
      checks++;
      if (stall_run > 1) begin
        errors++;
        $display("FAIL R4 [%s] stall repeated actual=%0d expected<=1", seg, stall_run);
      end
    end else stall_run = 0;

    n = '{default: 0};
    if (real_i && !exp_stall) begin
      n.live = 1; n.longop = (c.op == 2'b10); n.rd = c.rd;
      if (c.op == 2'b01 && (hs || ht)) begin
        if (slow) begin n.late = 1; n.f2 = {ht, hs}; end
        else      n.f1 = {ht, hs};
      end
    end
    m2 = m1;
    m1 = n;
    if (!exp_stall && prog.size() > 0) void'(prog.pop_front());
  endtask

  task automatic run(string tag);
    seg = tag;
    while (prog.size() > 0) step();
    repeat (3) step();
  endtask

  initial begin
    m1 = '{default: 0};
    m2 = '{default: 0};
    seg = "R1";
    // R1: reset clears state even with a dependent long subtract in decode.
    id_valid = 1; id_op = 2'b10; id_rd = 5'd3; id_rs = 5'd1; id_rt = 5'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "stall in reset", stall, 1'b0);
    chk("R1", "ex1_post in reset", ex1_post, 1'b0);
    chk("R1", "ex1_fwd_rs in reset", ex1_fwd_rs, 1'b0);
    chk("R1", "ex2_post in reset", ex2_post, 1'b0);
    chk("R1", "ex2_fwd_rt in reset", ex2_fwd_rt, 1'b0);
    rst = 1'b0;
    id_valid = 0;

    // R5, R3: short after short, both sources and single sources.
    put(1, 1, 1, 2, 3); put(1, 1, 4, 1, 1); put(1, 1, 5, 4, 7); put(1, 1, 6, 8, 5);
    run("R5");
    // R2, R4: long subtract depending on the instruction ahead.
    put(1, 1, 1, 2, 3); put(1, 2, 2, 1, 3); put(1, 2, 3, 9, 9); put(1, 2, 4, 5, 3);
    put(1, 2, 5, 4, 4);
    run("R4");
    // R6: deferral after a long subtract, then a chain of deferred short subtracts.
    put(1, 2, 6, 1, 1); put(1, 1, 7, 6, 2); put(1, 1, 8, 9, 7); put(1, 1, 10, 8, 8);
    put(1, 1, 11, 1, 2); put(1, 1, 12, 11, 3);
    run("R6");
    // R7: independent short subtracts.
    put(1, 1, 1, 2, 3); put(1, 1, 4, 5, 6); put(1, 1, 7, 8, 9);
    run("R7");
    // R8: producers two slots back.
    put(1, 2, 3, 1, 1); put(1, 0, 0, 0, 0); put(1, 1, 4, 3, 3);
    put(1, 2, 3, 1, 1); put(1, 1, 9, 1, 2); put(1, 2, 5, 3, 3);
    run("R8");
    // R9: register 0, no-op, reserved code and idle slot never match.
    put(1, 1, 0, 1, 2); put(1, 2, 4, 0, 0); put(1, 0, 5, 0, 0); put(1, 2, 6, 5, 5);
    put(1, 3, 6, 0, 0); put(1, 2, 7, 6, 6); put(0, 1, 7, 0, 0); put(1, 2, 8, 7, 7);
    put(1, 1, 9, 1, 1); put(1, 1, 10, 0, 0);
    run("R9");
    // R10: one source matching, the other not.
    put(1, 1, 1, 2, 3); put(1, 1, 2, 3, 1); put(1, 2, 5, 1, 1); put(1, 1, 6, 9, 5);
    run("R10");
    // R11: long subtract after long subtract, stalled then plain.
    put(1, 2, 1, 2, 3); put(1, 2, 2, 1, 1); put(1, 2, 3, 2, 4);
    run("R11");
    // Random stream over a small register set.
    for (int k = 0; k < 400; k++)
      put(($urandom_range(0, 9) != 0), 2'($urandom_range(0, 3)),
          $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
    run("R2 R6 random");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule